// File: doc/BRIEF.md
# Sound-Chip Access Wait-State Generator

This block sits beside the register interface of a sound chip and decides how long the host bus has to stall for each register access. The register interface has already decided whether an access is valid. For every access it presents a strobe, a flag that marks a rejected access, a tag that identifies the instruction that issued it, a flag for multi-register block-move instructions, and a flag for the write half of a read-modify-write instruction. In the same cycle, the block answers with a stall request that carries a cycle count.

The penalty is charged once per instruction, not once per access. The first accepted access of a new instruction stalls the bus. Further accesses from the same instruction are free, with two exceptions. A block move is charged again on every fourth access it makes, counted from zero. The write half of a read-modify-write is charged a second time. Rejected accesses cost nothing and leave the block's state untouched.

Top module: `psg_wait_gen`

## Requirements
- R1: While reset is held, and on the first clock after it is released with no access present, `stall_req` is 0 and `stall_cycles` is 0. The first accepted access after reset is always treated as belonging to a new instruction.
- R2: An accepted access (`acc_valid`=1, `acc_ignored`=0) whose `acc_tag` differs from the tag of the last accepted access raises `stall_req` in that same cycle, with `stall_cycles` = 4.
- R3: An accepted access with the same tag as the last accepted access, with `acc_blk`=0 and `acc_rmw_wr`=0, gives `stall_req`=0.
- R4: Accepted accesses are numbered 0, 1, 2, … within an instruction, and the number restarts at 0 when the tag changes. For a block move (`acc_blk`=1), every access whose number is a multiple of 4 (0, 4, 8, …) requests a 4-cycle stall.
- R5: A block move that writes N registers, with two accesses per register, accumulates 4·ceil(N/2) stall cycles. For example, 3 registers give 8 cycles and 8 registers give 16 cycles.
- R6: An access with `acc_ignored`=1 never raises `stall_req`. It changes neither the stored tag nor the access number, so the next accepted access behaves as if the rejected one had not happened.
- R7: An accepted access with `acc_rmw_wr`=1 requests a 4-cycle stall even when its tag matches the previous access.
- R8: `stall_cycles` is 3'b100 whenever `stall_req` is 1, and 3'b000 whenever `stall_req` is 0.
- R9: A cycle with `acc_valid`=0 gives `stall_req`=0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A register access is present this cycle |
| acc_ignored | input | 1 | The register interface rejected this access |
| acc_tag | input | TAG_W (4) | Identifier of the instruction issuing the access |
| acc_blk | input | 1 | The issuing instruction is a multi-register block move |
| acc_rmw_wr | input | 1 | This access is the write half of a read-modify-write |
| stall_req | output | 1 | Stall request pulse, in the same cycle as the access |
| stall_cycles | output | 3 | Number of stall cycles requested |

## Verification
The bench aims at the boundaries of the per-instruction counter. These are the fourth and eighth accesses of long block moves, block moves of odd and even register counts, and a new tag that arrives straight after a block move. A design that counted from 1 or reset its count late would shift every extra charge by one access, and the R5 totals would be wrong. Rejected accesses are placed between accesses that share a tag, and some carry a fresh tag. A design that let a rejected access update the stored tag or the count would charge the following accepted access, or skip a charge it owed. Repeated accesses from a read-modify-write show whether the write half is charged a second time.

// File: rtl/psg_ws_pkg.sv
package psg_ws_pkg;

  localparam int unsigned STALL_W = 3;

  // Charge rule: a new instruction, the write half of a read-modify-write,
  // or a block-move access whose number within the instruction is a
  // multiple of four.
  function automatic logic charge_due(input logic first_acc,
                                      input logic blk,
                                      input logic rmw_wr,
                                      input logic [1:0] idx_lo);
    return first_acc | rmw_wr | (blk & (idx_lo == 2'b00));
  endfunction

endpackage

// File: rtl/ws_insn_tracker.sv
module ws_insn_tracker #(
  parameter int unsigned TAG_W = 4,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [TAG_W-1:0] tag,
  output logic             first_acc,
  output logic [IDX_W-1:0] idx
);

  logic [TAG_W-1:0] tag_q;
  logic             seen_q;
  logic [IDX_W-1:0] idx_q;

  assign first_acc = !seen_q || (tag != tag_q);
  assign idx       = first_acc ? '0 : idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q  <= '0;
      seen_q <= 1'b0;
      idx_q  <= '0;
    end else if (take) begin
      tag_q  <= tag;
      seen_q <= 1'b1;
      idx_q  <= idx + 1'b1;
    end
  end

endmodule

// File: rtl/ws_charge_unit.sv
module ws_charge_unit
  import psg_ws_pkg::*;
#(
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned WAIT_CYC = 4
) (
  input  logic               take,
  input  logic               first_acc,
  input  logic               blk,
  input  logic               rmw_wr,
  input  logic [IDX_W-1:0]   idx,
  output logic               req,
  output logic [STALL_W-1:0] cycles
);

  localparam logic [STALL_W-1:0] WAIT_V = STALL_W'(WAIT_CYC);

  assign req    = take && charge_due(first_acc, blk, rmw_wr, idx[1:0]);
  assign cycles = req ? WAIT_V : '0;

endmodule

// File: rtl/psg_wait_gen.sv
module psg_wait_gen
  import psg_ws_pkg::*;
#(
  parameter int unsigned TAG_W    = 4,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned WAIT_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_ignored,
  input  logic [TAG_W-1:0] acc_tag,
  input  logic             acc_blk,
  input  logic             acc_rmw_wr,
  output logic             stall_req,
  output logic [2:0]       stall_cycles
);

  logic             take;
  logic             first_acc;
  logic [IDX_W-1:0] acc_idx;

  assign take = acc_valid && !acc_ignored;

  ws_insn_tracker #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_track (
    .clk(clk), .rst_n(rst_n), .take(take), .tag(acc_tag),
    .first_acc(first_acc), .idx(acc_idx)
  );

  ws_charge_unit #(.IDX_W(IDX_W), .WAIT_CYC(WAIT_CYC)) u_charge (
    .take(take), .first_acc(first_acc), .blk(acc_blk), .rmw_wr(acc_rmw_wr),
    .idx(acc_idx), .req(stall_req), .cycles(stall_cycles)
  );

endmodule

// File: rtl/psg_wait_gen_chk.sv
module psg_wait_gen_chk #(
  parameter int unsigned WAIT_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_valid,
  input logic       acc_ignored,
  input logic       acc_blk,
  input logic       acc_rmw_wr,
  input logic       take,
  input logic       first_acc,
  input logic       stall_req,
  input logic [2:0] stall_cycles
);

  // R2: a new instruction is always charged
  p_new_insn_charged_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && first_acc) |-> stall_req);

  // R3: repeat plain access within an instruction is free
  p_repeat_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !first_acc && !acc_blk && !acc_rmw_wr) |-> !stall_req);

  // R6: rejected accesses never stall
  p_ignored_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ignored) |-> !stall_req);

  // R7: read-modify-write write half is charged
  p_rmw_charged_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && acc_rmw_wr) |-> stall_req);

  // R8: count matches request
  p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |-> (stall_cycles == 3'(WAIT_CYC)));
  p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_req |-> (stall_cycles == 3'b000));

  // R9: no access, no stall
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !stall_req);

endmodule

bind psg_wait_gen psg_wait_gen_chk #(.WAIT_CYC(WAIT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ignored(acc_ignored),
  .acc_blk(acc_blk), .acc_rmw_wr(acc_rmw_wr), .take(take),
  .first_acc(first_acc), .stall_req(stall_req), .stall_cycles(stall_cycles)
);

// File: tb/tb_psg_wait_gen.sv
`timescale 1ns/1ps
module tb_psg_wait_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic       acc_ignored = 1'b0;
  logic [3:0] acc_tag = '0;
  logic       acc_blk = 1'b0;
  logic       acc_rmw_wr = 1'b0;
  logic       stall_req;
  logic [2:0] stall_cycles;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  int m_prev_tag = -1;
  int m_idx = 0;
  int sum_cyc = 0;

  always #5 clk = ~clk;

  psg_wait_gen dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ignored(acc_ignored),
    .acc_tag(acc_tag), .acc_blk(acc_blk), .acc_rmw_wr(acc_rmw_wr),
    .stall_req(stall_req), .stall_cycles(stall_cycles)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle: drive, compare against the reference, advance the reference.
  task automatic cycle(input bit v, input bit ign, input int tag,
                       input bit blk, input bit rmw, input string req);
    bit accepted, new_insn, exp_req;
    int idx_now;
    @(negedge clk);
    acc_valid = v; acc_ignored = ign; acc_tag = tag[3:0];
    acc_blk = blk; acc_rmw_wr = rmw;
    #2;
    accepted = v && !ign;
    new_insn = (m_prev_tag != tag);
    idx_now  = new_insn ? 0 : m_idx;
    exp_req  = accepted && (new_insn || rmw || (blk && (idx_now % 4 == 0)));
    check(req, int'(stall_req), int'(exp_req));
    check("R8", int'(stall_cycles), exp_req ? 4 : 0);
    if (stall_req) sum_cyc += int'(stall_cycles);
    if (accepted) begin
      m_prev_tag = tag;
      m_idx = idx_now + 1;
    end
  endtask

  task automatic block_move(input int tag, input int nregs, input string req);
    sum_cyc = 0;
    for (int i = 0; i < 2 * nregs; i++) cycle(1, 0, tag, 1, 0, "R4");
    check(req, sum_cyc, 4 * ((nregs + 1) / 2));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #2;
    check("R1", int'(stall_req), 0);
    check("R1", int'(stall_cycles), 0);
    @(negedge clk); rst_n = 1'b1;
    cycle(0, 0, 0, 0, 0, "R1");
    cycle(0, 0, 5, 1, 1, "R9");
    cycle(1, 0, 0, 0, 0, "R1");   // tag 0 still new after reset
    cycle(1, 0, 0, 0, 0, "R3");
    cycle(1, 0, 1, 0, 0, "R2");
    cycle(1, 0, 1, 0, 0, "R3");
    cycle(1, 0, 1, 0, 0, "R3");
    cycle(0, 0, 9, 0, 0, "R9");
    cycle(1, 0, 1, 0, 0, "R9");   // idle did not reset state
    cycle(1, 0, 2, 0, 0, "R2");
    cycle(1, 0, 2, 0, 1, "R7");
    cycle(1, 0, 2, 0, 1, "R7");
    cycle(1, 0, 2, 0, 0, "R3");
    cycle(1, 1, 3, 0, 0, "R6");   // rejected new tag
    cycle(1, 0, 2, 0, 0, "R6");   // tag not updated: still free
    cycle(1, 1, 2, 0, 1, "R6");
    block_move(4, 8, "R5");
    block_move(5, 3, "R5");
    block_move(6, 1, "R5");
    block_move(7, 2, "R5");
    block_move(8, 15, "R5");
    // block move with rejected accesses mixed in
    cycle(1, 0, 9, 1, 0, "R4");
    cycle(1, 0, 9, 1, 0, "R4");
    cycle(1, 1, 9, 1, 0, "R6");
    cycle(1, 1, 9, 1, 0, "R6");
    cycle(1, 0, 9, 1, 0, "R4");
    cycle(1, 0, 9, 1, 0, "R4");   // index 3
    cycle(1, 0, 9, 1, 0, "R4");   // index 4: charged
    cycle(1, 0, 10, 0, 0, "R2");
    cycle(1, 0, 9, 0, 0, "R2");
    // reset mid-instruction
    @(negedge clk); rst_n = 1'b0; acc_valid = 1'b0;
    @(negedge clk); #2;
    check("R1", int'(stall_req), 0);
    rst_n = 1'b1; m_prev_tag = -1; m_idx = 0;
    cycle(1, 0, 9, 0, 0, "R1");
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule